// File: doc/BRIEF.md
# Address-Encoded Host Port to ISA I/O Bridge

This block lets a host that can only read through a narrow port drive a small ISA I/O slot. The host port has address lines, a request strobe and a 16-bit data bus that only the block drives. Every host access is therefore a read. The block turns each host access into exactly one ISA I/O cycle. A single window bit in the host address selects the direction. When it is clear, the access becomes an ISA read and the peripheral's data is returned on the host data bus. When it is set, the access becomes an ISA write. The byte to write travels on a group of host address lines, because the host cannot drive data.

The ISA register number comes from host address bits 13..9. It is placed on the five low ISA address bits. The upper ISA address bits are fixed to an I/O base of 0x300. A mode input selects byte operation or word operation. In word mode a read returns all sixteen peripheral data bits unchanged. A word write needs two host accesses. The first goes to the read window and leaves the low byte in a holding register. The second goes to the write window, carries the high byte, and completes one 16-bit ISA write.

The host request uses a valid/ready handshake. The host raises `host_valid` with a stable address and holds both until it sees `host_ready`. The transfer takes place on the clock edge where both are high, and `host_rdata` is valid in that same cycle. The block applies back-pressure simply by withholding `host_ready` until the ISA strobe has finished. A host that keeps `host_valid` high after the transfer edge starts a new access.

Top module: `rom_isa_bridge`

## Requirements
- R1: After reset, `isa_ior_n` and `isa_iow_n` are high, `isa_dout_en` and `host_ready` are low, and the holding register is empty. An empty holding register means a word-mode write-window access made first is a byte write.
- R2: During every ISA cycle, `isa_addr` equals 0x300 OR host address bits 13..9.
- R3: A host access with address bit 16 clear produces exactly one ISA read strobe and no write strobe.
- R4: A host access with address bit 16 set produces exactly one ISA write strobe and no read strobe. `isa_dout_en` is high while the write strobe is low.
- R5: In byte mode a read returns `{isa_din[7:0], 8'h00}` on `host_rdata`, and `isa_wide` is low during the strobe.
- R6: A byte write drives `{8'h00, host_addr[8:1]}` on `isa_dout` with `isa_wide` low. A write-window access returns 0x0000 on `host_rdata`.
- R7: In word mode a read returns `isa_din[15:0]` unchanged, and `isa_wide` is high during the strobe.
- R8: A word-mode read-window access stores host address bits 8..1 in the holding register. A later word-mode write-window access then drives `{host_addr[8:1], stored byte}` with `isa_wide` high. When that write ends the holding register is emptied.
- R9: Byte-mode read-window accesses never load the holding register.
- R10: A word-mode write-window access made while the holding register is empty is a plain byte write, as in R6.
- R11: Each ISA strobe stays low for exactly STROBE_CLKS clocks. The two strobes are never low together. `isa_addr` and `isa_dout` are stable from one clock before the strobe falls until one clock after it rises.
- R12: Host address bits 0, 14 and 15 have no effect on the ISA cycle or on the returned data.
- R13: `host_ready` is high for one clock per access, and only while both strobes are high after the strobe has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| word_mode | input | 1 | 1 = word operation, 0 = byte operation; sampled when an access is accepted |
| host_valid | input | 1 | Host access request |
| host_addr | input | HOST_AW (17) | Host address; bit 16 selects the window |
| host_ready | output | 1 | Access complete; a one-clock pulse |
| host_rdata | output | 16 | Data returned to the host, valid while host_ready is high |
| isa_addr | output | ISA_AW (10) | ISA I/O address |
| isa_ior_n | output | 1 | ISA I/O read strobe, active low |
| isa_iow_n | output | 1 | ISA I/O write strobe, active low |
| isa_dout | output | 16 | ISA write data |
| isa_dout_en | output | 1 | ISA write data drive enable |
| isa_wide | output | 1 | Current ISA cycle is 16 bits wide |
| isa_din | input | 16 | ISA read data from the peripheral |

## Verification
The hardest state to reach from the ports is a holding register whose content is left over from an earlier, unrelated access. Examples are a low byte captured several accesses before the completing write, a byte-mode read placed between the capture and the write, or a second word write issued after the first one has emptied the register. The stimulus mixes directed sequences that build each of these orderings with long random runs. The random runs pick the mode and the window on every access. The bench keeps its own model of the holding register and its flag, so every write has an exact expected width and data word.

// File: rtl/rib_pkg.sv
package rib_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_SETUP,
    SQ_PULSE,
    SQ_HOLD
  } seq_state_t;

  typedef struct packed {
    logic wr;        // write window selected
    logic wide;      // 16-bit ISA cycle
    logic use_hold;  // completes a split word write
  } xfer_kind_t;
endpackage

// File: rtl/rib_decode.sv
module rib_decode
  import rib_pkg::*;
#(
  parameter int HOST_AW  = 17,
  parameter int WIN_BIT  = 16,
  parameter int REG_LSB  = 9,
  parameter int REG_BITS = 5,
  parameter int DAT_LSB  = 1
) (
  input  logic [HOST_AW-1:0]  addr,
  input  logic                word_mode,
  input  logic                hold_vld,
  output xfer_kind_t          kind,
  output logic [REG_BITS-1:0] reg_idx,
  output logic [BYTE_W-1:0]   byte_val
);
  always_comb begin
    kind.wr       = addr[WIN_BIT];
    kind.use_hold = addr[WIN_BIT] & word_mode & hold_vld;
    kind.wide     = word_mode & (~addr[WIN_BIT] | hold_vld);
    reg_idx       = addr[REG_LSB +: REG_BITS];
    byte_val      = addr[DAT_LSB +: BYTE_W];
  end
endmodule

// File: rtl/rib_hold.sv
module rib_hold
  import rib_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [BYTE_W-1:0] cap_byte,
  input  logic              drain,
  output logic [BYTE_W-1:0] lo_byte,
  output logic              vld
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_byte <= '0;
      vld     <= 1'b0;
    end else if (capture) begin
      lo_byte <= cap_byte;
      vld     <= 1'b1;
    end else if (drain) begin
      vld     <= 1'b0;
    end
  end
endmodule

// File: rtl/rib_seq.sv
module rib_seq
  import rib_pkg::*;
#(
  parameter int STROBE_CLKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic idle,
  output logic in_pulse,
  output logic last_pulse,
  output logic in_hold
);
  localparam int CW = $clog2(STROBE_CLKS + 1);
  localparam logic [CW-1:0] LAST = CW'(STROBE_CLKS - 1);

  seq_state_t state;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SQ_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        SQ_IDLE:  if (start) state <= SQ_SETUP;
        SQ_SETUP: begin
          state <= SQ_PULSE;
          cnt   <= '0;
        end
        SQ_PULSE: begin
          if (cnt == LAST) state <= SQ_HOLD;
          cnt <= cnt + 1'b1;
        end
        default:  state <= SQ_IDLE;
      endcase
    end
  end

  always_comb begin
    idle       = (state == SQ_IDLE);
    in_pulse   = (state == SQ_PULSE);
    last_pulse = in_pulse && (cnt == LAST);
    in_hold    = (state == SQ_HOLD);
  end
endmodule

// File: rtl/rom_isa_bridge.sv
module rom_isa_bridge
  import rib_pkg::*;
#(
  parameter int              HOST_AW     = 17,
  parameter int              WIN_BIT     = 16,
  parameter int              REG_LSB     = 9,
  parameter int              REG_BITS    = 5,
  parameter int              DAT_LSB     = 1,
  parameter int              ISA_AW      = 10,
  parameter logic [ISA_AW-1:0] IO_BASE   = 10'h300,
  parameter int              STROBE_CLKS = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               word_mode,
  input  logic               host_valid,
  input  logic [HOST_AW-1:0] host_addr,
  output logic               host_ready,
  output logic [WORD_W-1:0]  host_rdata,
  output logic [ISA_AW-1:0]  isa_addr,
  output logic               isa_ior_n,
  output logic               isa_iow_n,
  output logic [WORD_W-1:0]  isa_dout,
  output logic               isa_dout_en,
  output logic               isa_wide,
  input  logic [WORD_W-1:0]  isa_din
);
  xfer_kind_t          kind_d, kind_r;
  logic [REG_BITS-1:0] reg_idx;
  logic [BYTE_W-1:0]   byte_val, hold_lo;
  logic                hold_vld;
  logic                idle, in_pulse, last_pulse, in_hold;
  logic                accept;
  logic [WORD_W-1:0]   wdata_d, rdata_d;

  rib_decode #(
    .HOST_AW(HOST_AW), .WIN_BIT(WIN_BIT), .REG_LSB(REG_LSB),
    .REG_BITS(REG_BITS), .DAT_LSB(DAT_LSB)
  ) u_dec (
    .addr(host_addr), .word_mode(word_mode), .hold_vld(hold_vld),
    .kind(kind_d), .reg_idx(reg_idx), .byte_val(byte_val)
  );

  rib_seq #(.STROBE_CLKS(STROBE_CLKS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept), .idle(idle),
    .in_pulse(in_pulse), .last_pulse(last_pulse), .in_hold(in_hold)
  );

  rib_hold u_hold (
    .clk(clk), .rst_n(rst_n),
    .capture(accept && word_mode && !kind_d.wr),
    .cap_byte(byte_val),
    .drain(in_hold && kind_r.use_hold),
    .lo_byte(hold_lo), .vld(hold_vld)
  );

  assign accept  = host_valid && idle;
  assign wdata_d = kind_d.use_hold ? {byte_val, hold_lo} : {8'h00, byte_val};
  assign rdata_d = kind_r.wr   ? '0 :
                   kind_r.wide ? isa_din : {isa_din[BYTE_W-1:0], 8'h00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_r     <= '0;
      isa_addr   <= IO_BASE;
      isa_dout   <= '0;
      host_rdata <= '0;
    end else begin
      if (accept) begin
        kind_r   <= kind_d;
        isa_addr <= IO_BASE | ISA_AW'(reg_idx);
        if (kind_d.wr) isa_dout <= wdata_d;
      end
      if (last_pulse) host_rdata <= rdata_d;
    end
  end

  assign isa_ior_n   = ~(in_pulse && !kind_r.wr);
  assign isa_iow_n   = ~(in_pulse && kind_r.wr);
  assign isa_dout_en = kind_r.wr && !idle;
  assign isa_wide    = kind_r.wide && !idle;
  assign host_ready  = in_hold;
endmodule

// File: rtl/rom_isa_bridge_chk.sv
module rom_isa_bridge_chk #(
  parameter int ISA_AW      = 10,
  parameter int STROBE_CLKS = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_ready,
  input logic [ISA_AW-1:0] isa_addr,
  input logic              isa_ior_n,
  input logic              isa_iow_n,
  input logic [15:0]       isa_dout,
  input logic              isa_dout_en
);
  logic [31:0] low_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_cnt <= '0;
    else if (!isa_ior_n || !isa_iow_n) low_cnt <= low_cnt + 1;
    else low_cnt <= '0;
  end

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    isa_ior_n || isa_iow_n);
  // R11
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(isa_ior_n) || $rose(isa_iow_n)) |-> low_cnt == 32'(STROBE_CLKS));
  // R11
  addr_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(isa_ior_n) || $fell(isa_iow_n)) |-> $stable(isa_addr) && $stable(isa_dout));
  // R11
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(isa_ior_n) || $rose(isa_iow_n)) |-> $stable(isa_addr) && $stable(isa_dout));
  // R4
  wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !isa_iow_n |-> isa_dout_en);
  // R13
  ready_idle_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |-> isa_ior_n && isa_iow_n);
  // R13
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |=> !host_ready);
endmodule

bind rom_isa_bridge rom_isa_bridge_chk #(.ISA_AW(ISA_AW), .STROBE_CLKS(STROBE_CLKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_ready(host_ready), .isa_addr(isa_addr),
  .isa_ior_n(isa_ior_n), .isa_iow_n(isa_iow_n), .isa_dout(isa_dout),
  .isa_dout_en(isa_dout_en)
);

// File: tb/rom_isa_bridge_test.sv
module rom_isa_bridge_test;
  localparam int N = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        word_mode = 1'b0;
  logic        host_valid = 1'b0;
  logic [16:0] host_addr = '0;
  logic        host_ready;
  logic [15:0] host_rdata;
  logic [9:0]  isa_addr;
  logic        isa_ior_n, isa_iow_n, isa_dout_en, isa_wide;
  logic [15:0] isa_dout;
  logic [15:0] isa_din = '0;

  int checks = 0, fails = 0;
  int nior = 0, niow = 0;
  logic [9:0]  seen_addr;
  logic [15:0] seen_dout, got_rdata;
  logic        seen_wide, seen_en;
  logic        m_vld = 1'b0;
  logic [7:0]  m_lo = '0;

  always #4 clk = ~clk;

  rom_isa_bridge #(.STROBE_CLKS(N)) uut (
    .clk(clk), .rst_n(rst_n), .word_mode(word_mode), .host_valid(host_valid),
    .host_addr(host_addr), .host_ready(host_ready), .host_rdata(host_rdata),
    .isa_addr(isa_addr), .isa_ior_n(isa_ior_n), .isa_iow_n(isa_iow_n),
    .isa_dout(isa_dout), .isa_dout_en(isa_dout_en), .isa_wide(isa_wide),
    .isa_din(isa_din)
  );

  always @(negedge clk) begin
    if (!isa_ior_n) begin
      nior <= nior + 1;
      seen_addr <= isa_addr; seen_wide <= isa_wide;
    end
    if (!isa_iow_n) begin
      niow <= niow + 1;
      seen_addr <= isa_addr; seen_dout <= isa_dout;
      seen_wide <= isa_wide; seen_en <= isa_dout_en;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_wdata(input logic wm, input logic [7:0] b);
    return (wm && m_vld) ? {b, m_lo} : {8'h00, b};
  endfunction

  task automatic access(input logic wm, input logic [16:0] a, input logic [15:0] din);
    logic [9:0]  ea;
    logic [7:0]  b;
    logic [15:0] ew;
    logic        ewide;
    @(negedge clk);
    nior = 0; niow = 0;
    word_mode = wm; isa_din = din; host_addr = a; host_valid = 1'b1;
    @(negedge clk);
    while (!host_ready) @(negedge clk);
    got_rdata = host_rdata;
    @(negedge clk);
    host_valid = 1'b0;
    ea = 10'h300 | {5'd0, a[13:9]};
    b  = a[8:1];
    chk(seen_addr == ea, "R2 isa_addr", seen_addr, ea);
    if (!a[16]) begin
      chk(nior == N && niow == 0, "R3 read strobe count", nior, N);
      chk(nior == N, "R11 read strobe width", nior, N);
      if (wm) begin
        chk(got_rdata == din, "R7 word read data", got_rdata, din);
        chk(seen_wide == 1'b1, "R7 wide flag", seen_wide, 1);
        m_lo = b; m_vld = 1'b1;
      end else begin
        chk(got_rdata == {din[7:0], 8'h00}, "R5 byte read data", got_rdata, {din[7:0], 8'h00});
        chk(seen_wide == 1'b0, "R5 narrow flag", seen_wide, 0);
      end
    end else begin
      ew = exp_wdata(wm, b);
      ewide = wm && m_vld;
      chk(niow == N && nior == 0, "R4 write strobe count", niow, N);
      chk(seen_en == 1'b1, "R4 drive enable", seen_en, 1);
      chk(seen_dout == ew, ewide ? "R8 word write data" : "R6 R10 byte write data", seen_dout, ew);
      chk(seen_wide == ewide, ewide ? "R8 wide flag" : "R10 narrow flag", seen_wide, ewide);
      chk(got_rdata == 16'h0000, "R6 write returns zero", got_rdata, 0);
      if (ewide) m_vld = 1'b0;
    end
  endtask

  initial begin
    int seed_sink;
    seed_sink = $urandom(32'h5eed_0001);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(isa_ior_n && isa_iow_n, "R1 strobes idle", {isa_ior_n, isa_iow_n}, 3);
    chk(!isa_dout_en && !host_ready, "R1 enables low", {isa_dout_en, host_ready}, 0);
    rst_n = 1'b1;
    // R1/R10: word write with empty holding register after reset
    access(1'b1, {1'b1, 2'b00, 5'h04, 8'hA5, 1'b0}, 16'h0);
    // R5 byte read, R6 byte write
    access(1'b0, {1'b0, 2'b00, 5'h1F, 8'h3C, 1'b0}, 16'hBEEF);
    access(1'b0, {1'b1, 2'b00, 5'h00, 8'hFF, 1'b1}, 16'h0);
    // R8 split word write; R9 byte read in between must not touch the holder
    access(1'b1, {1'b0, 2'b00, 5'h02, 8'h34, 1'b0}, 16'h1234);
    access(1'b0, {1'b0, 2'b00, 5'h02, 8'h99, 1'b0}, 16'h5678);
    access(1'b1, {1'b1, 2'b00, 5'h02, 8'h12, 1'b0}, 16'h0);
    // R8 holder emptied: next word write is narrow
    access(1'b1, {1'b1, 2'b00, 5'h02, 8'h56, 1'b0}, 16'h0);
    // R9 byte read alone never arms the holder
    access(1'b0, {1'b0, 2'b00, 5'h07, 8'h77, 1'b0}, 16'hCAFE);
    access(1'b1, {1'b1, 2'b00, 5'h07, 8'h11, 1'b0}, 16'h0);
    // R12 ignored bits 0, 14, 15 set
    access(1'b0, {1'b0, 2'b11, 5'h15, 8'h00, 1'b1}, 16'h00C3);
    access(1'b0, {1'b1, 2'b11, 5'h15, 8'h81, 1'b1}, 16'h0);
    // random mix
    for (int i = 0; i < 80; i++) begin
      access(1'($urandom), 17'($urandom), 16'($urandom));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 20000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule